// File: doc/BRIEF.md
# Scattered-Bit Interrupt Controller

This block gathers up to 64 interrupt sources into a single interrupt request for a processor. Each source owns one bit in either a high or a low 32-bit word. Each word has an enable mask and a pending register. The assignment of sources to bits follows a fixed, non-linear scatter: some ranges run in reversed order, one range runs in ascending order, and two sources share a bit. Software enables sources through the masks and acknowledges them by writing ones to the pending words. To find out which source to service, software reads a vector word that carries the selected source number in its top six bits.

Each source has its own 2-bit sense code, which makes it level-sensitive (either polarity) or edge-sensitive (either edge). Every source input passes through a two-flop synchroniser before edge or level detection. The selection rule is fixed: the lowest-numbered source that is both pending and enabled wins. Number 0 is reserved to mean "nothing pending". A configuration word and two priority words are kept for software and can be read back, but they do not change the selection.

Top module: `scatter_intc`

## Requirements
- R1: After reset the two masks, the two pending words, the vector and the configuration word read 0, both priority words read 0x05309770, and `irq_o` is low.
- R2: Sources 0-15 and 32-47 live in the high word (mask at address 0, pending at address 2). Source 0 uses bit 0, source k for k = 1..15 uses bit 16-k, and source k for k = 32..47 uses bit 63-k.
- R3: Sources 16-31 and 48-63 live in the low word (mask at address 1, pending at address 3). Sources 16, 17 and 18 use bits 2, 1 and 0. Source k for k = 19..30 uses bit 33-k. Source 31 shares bit 0 with source 18. Source k for k = 48..63 uses bit k-32.
- R4: A mask bit of 1 enables its source and 0 masks it. A masked source still shows in its pending word but never raises `irq_o` and is never reported in the vector.
- R5: Writing a pending word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R6: The sense code of source s is `sense_i[2s+1:2s]`: 0 is active-low level, 1 is active-high level, 2 is falling edge, 3 is rising edge. Any other input activity sets nothing. After an input changes between two rising clock edges, its pending bit is set at the third rising edge that follows.
- R7: A level source whose level is still active stays pending when it is cleared.
- R8: When a hardware set and a software clear hit the same pending bit in one cycle, the bit ends up set.
- R9: The vector (address 4) holds in bits 31:26 the lowest source number in 1..63 whose bit is both pending and enabled. All its other bits are 0. It reads 0 when there is no such source. Source 0 is never reported and never raises `irq_o`.
- R10: `irq_o` is high exactly when the vector is nonzero.
- R11: The configuration word (address 5) and the priority words (addresses 6 and 7) read back what was written and have no effect on the vector or `irq_o`. Writes to address 4 are ignored. Read data appears on `rdata` one clock after `addr` is presented.
- R12: An edge source that holds a steady level after its edge is pending once. Once cleared, it stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Raw interrupt source lines, bit s is source s |
| sense_i | input | 128 | Per-source 2-bit sense code |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A wrong entry in the scatter table appears as an unexpected bit in a pending word and as a wrong vector number. Both show on the first read after a single source fires, three clocks after the input moves. A broken acknowledge or set-versus-clear rule shows as a pending bit that is still set, or already gone, on the read that follows the clearing write. A faulty priority encoder shows as a wrong vector number, or as `irq_o` disagreeing with the vector, in the same cycle that the pending state settles.

// File: rtl/scatter_intc_pkg.sv
package scatter_intc_pkg;
  localparam int NSRC     = 64;
  localparam int DW       = 32;
  localparam int AW       = 3;
  localparam int SELW     = $clog2(NSRC);
  localparam int VEC_LSB  = DW - SELW;
  localparam int BITW     = $clog2(DW);
  localparam logic [DW-1:0] PRIO_RST = 32'h0530_9770;

  typedef enum logic [AW-1:0] {
    A_MASK_HI = 3'd0,
    A_MASK_LO = 3'd1,
    A_PEND_HI = 3'd2,
    A_PEND_LO = 3'd3,
    A_VECTOR  = 3'd4,
    A_CONFIG  = 3'd5,
    A_PRIO_HI = 3'd6,
    A_PRIO_LO = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    SNS_LVL_LOW  = 2'd0,
    SNS_LVL_HIGH = 2'd1,
    SNS_FALL     = 2'd2,
    SNS_RISE     = 2'd3
  } sense_e;

  // Source lives in the high word when its 16-source group number is even.
  function automatic logic src_in_high(input int s);
    return ((s >> 4) & 1) == 0;
  endfunction

  // Bit position of a source inside its word.
  function automatic logic [BITW-1:0] src_bit(input int s);
    int b;
    if (s < 16)      b = (s == 0) ? 0 : 16 - s;
    else if (s < 32) b = (s <= 18) ? 18 - s : ((s == 31) ? 0 : 33 - s);
    else if (s < 48) b = 63 - s;
    else             b = s - 32;
    return BITW'(b);
  endfunction
endpackage

// File: rtl/scatter_intc_sync.sv
module scatter_intc_sync
  import scatter_intc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   src_i,
  input  logic [2*N-1:0] sense_i,
  output logic [N-1:0]   set_o
);
  logic [N-1:0] stg1, stg2, stg3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1 <= '0;
      stg2 <= '0;
      stg3 <= '0;
    end else begin
      stg1 <= src_i;
      stg2 <= stg1;
      stg3 <= stg2;
    end
  end

  for (genvar s = 0; s < N; s++) begin : g_src
    always_comb begin
      unique case (sense_e'(sense_i[2*s +: 2]))
        SNS_LVL_LOW:  set_o[s] = ~stg2[s];
        SNS_LVL_HIGH: set_o[s] =  stg2[s];
        SNS_FALL:     set_o[s] = ~stg2[s] &  stg3[s];
        default:      set_o[s] =  stg2[s] & ~stg3[s];
      endcase
    end
  end
endmodule

// File: rtl/scatter_intc_route.sv
module scatter_intc_route
  import scatter_intc_pkg::*;
(
  input  logic [NSRC-1:0] set_src_i,
  input  logic [DW-1:0]   pend_hi_i,
  input  logic [DW-1:0]   pend_lo_i,
  input  logic [DW-1:0]   mask_hi_i,
  input  logic [DW-1:0]   mask_lo_i,
  output logic [DW-1:0]   set_hi_o,
  output logic [DW-1:0]   set_lo_o,
  output logic [NSRC-1:0] hit_o
);
  always_comb begin
    set_hi_o = '0;
    set_lo_o = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (src_in_high(s)) set_hi_o[src_bit(s)] = set_hi_o[src_bit(s)] | set_src_i[s];
      else                set_lo_o[src_bit(s)] = set_lo_o[src_bit(s)] | set_src_i[s];
    end
  end

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      if (src_in_high(s)) hit_o[s] = pend_hi_i[src_bit(s)] & mask_hi_i[src_bit(s)];
      else                hit_o[s] = pend_lo_i[src_bit(s)] & mask_lo_i[src_bit(s)];
    end
  end
endmodule

// File: rtl/scatter_intc_pend.sv
module scatter_intc_pend
  import scatter_intc_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  // A hardware set beats a software clear on the same bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/scatter_intc_prio.sv
module scatter_intc_prio
  import scatter_intc_pkg::*;
(
  input  logic [NSRC-1:0] hit_i,
  output logic [SELW-1:0] sel_o,
  output logic            valid_o
);
  // Number 0 is reserved for "none", so the scan stops at source 1.
  always_comb begin
    sel_o   = '0;
    valid_o = 1'b0;
    for (int s = NSRC - 1; s >= 1; s--) begin
      if (hit_i[s]) begin
        sel_o   = SELW'(s);
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/scatter_intc.sv
module scatter_intc
  import scatter_intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [2*NSRC-1:0] sense_i,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq_o
);
  logic [DW-1:0]   mask_hi, mask_lo, pend_hi, pend_lo;
  logic [DW-1:0]   set_hi, set_lo, clr_hi, clr_lo;
  logic [DW-1:0]   cfg_q, prio_hi_q, prio_lo_q, vector;
  logic [NSRC-1:0] set_src, hit;
  logic [SELW-1:0] sel_src;
  logic            sel_valid;
  reg_addr_e       a;

  assign a = reg_addr_e'(addr);

  scatter_intc_sync #(.N(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .sense_i(sense_i), .set_o(set_src)
  );

  scatter_intc_route u_route (
    .set_src_i(set_src), .pend_hi_i(pend_hi), .pend_lo_i(pend_lo),
    .mask_hi_i(mask_hi), .mask_lo_i(mask_lo),
    .set_hi_o(set_hi), .set_lo_o(set_lo), .hit_o(hit)
  );

  assign clr_hi = (wr_en && a == A_PEND_HI) ? wdata : '0;
  assign clr_lo = (wr_en && a == A_PEND_LO) ? wdata : '0;

  scatter_intc_pend #(.W(DW)) u_pend_hi (
    .clk(clk), .rst_n(rst_n), .set_i(set_hi), .clr_i(clr_hi), .pend_o(pend_hi)
  );
  scatter_intc_pend #(.W(DW)) u_pend_lo (
    .clk(clk), .rst_n(rst_n), .set_i(set_lo), .clr_i(clr_lo), .pend_o(pend_lo)
  );

  scatter_intc_prio u_prio (.hit_i(hit), .sel_o(sel_src), .valid_o(sel_valid));

  assign vector = sel_valid ? {sel_src, {VEC_LSB{1'b0}}} : '0;
  assign irq_o  = sel_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_hi   <= '0;
      mask_lo   <= '0;
      cfg_q     <= '0;
      prio_hi_q <= PRIO_RST;
      prio_lo_q <= PRIO_RST;
    end else if (wr_en) begin
      unique case (a)
        A_MASK_HI: mask_hi   <= wdata;
        A_MASK_LO: mask_lo   <= wdata;
        A_CONFIG:  cfg_q     <= wdata;
        A_PRIO_HI: prio_hi_q <= wdata;
        A_PRIO_LO: prio_lo_q <= wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else begin
      unique case (a)
        A_MASK_HI: rdata <= mask_hi;
        A_MASK_LO: rdata <= mask_lo;
        A_PEND_HI: rdata <= pend_hi;
        A_PEND_LO: rdata <= pend_lo;
        A_VECTOR:  rdata <= vector;
        A_CONFIG:  rdata <= cfg_q;
        A_PRIO_HI: rdata <= prio_hi_q;
        default:   rdata <= prio_lo_q;
      endcase
    end
  end
endmodule

// File: rtl/scatter_intc_chk.sv
module scatter_intc_chk
  import scatter_intc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            irq_o,
  input logic [DW-1:0]   set_hi,
  input logic [DW-1:0]   set_lo,
  input logic [DW-1:0]   clr_hi,
  input logic [DW-1:0]   clr_lo,
  input logic [DW-1:0]   pend_hi,
  input logic [DW-1:0]   pend_lo,
  input logic [DW-1:0]   mask_hi,
  input logic [DW-1:0]   mask_lo,
  input logic [SELW-1:0] sel_src,
  input logic            sel_valid
);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hi != '0 || set_lo != '0) |=>
      ((pend_hi & $past(set_hi)) == $past(set_hi)) && ((pend_lo & $past(set_lo)) == $past(set_lo)));

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_hi & ~set_hi) != '0 || (clr_lo & ~set_lo) != '0) |=>
      ((pend_hi & $past(clr_hi & ~set_hi)) == '0) && ((pend_lo & $past(clr_lo & ~set_lo)) == '0));

  assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_hi & ~$past(pend_hi) & ~$past(set_hi)) == '0) &&
                     ((pend_lo & ~$past(pend_lo) & ~$past(set_lo)) == '0));

  assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (((pend_hi & mask_hi) | (pend_lo & mask_lo)) != '0));

  assert_vector_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_src != '0));
endmodule

bind scatter_intc scatter_intc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o),
  .set_hi(set_hi), .set_lo(set_lo), .clr_hi(clr_hi), .clr_lo(clr_lo),
  .pend_hi(pend_hi), .pend_lo(pend_lo), .mask_hi(mask_hi), .mask_lo(mask_lo),
  .sel_src(sel_src), .sel_valid(sel_valid)
);

// File: tb/scatter_intc_bench.sv
module scatter_intc_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [63:0]  src_i = '0;
  logic [127:0] sense_i = '1;
  logic         wr_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  scatter_intc u_scatter_intc (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .sense_i(sense_i),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // Independent restatement of the scatter: group g = s/16, offset k = s%16.
  function automatic void loc(input int s, output bit hi, output int b);
    int g = s / 16;
    int k = s % 16;
    hi = (g == 0) || (g == 2);
    case (g)
      0: b = (k == 0) ? 0 : 16 - k;
      1: b = (k < 3) ? 2 - k : ((k == 15) ? 0 : 17 - k);
      2: b = 31 - k;
      default: b = 16 + k;
    endcase
  endfunction

  task automatic clean();
    wr(3'd0, 32'h0); wr(3'd1, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "irq after reset", {31'b0, irq_o}, 32'h0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1", $sformatf("reg %0d after reset", a), d, (a >= 6) ? 32'h0530_9770 : 32'h0);
    end
  endtask

  task automatic t_map();
    logic [31:0] dh, dl, dv;
    bit hi; int b; bit hi2; int b2;
    int ev;
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
    for (int s = 0; s < 64; s++) begin
      @(negedge clk); src_i[s] = 1'b1;
      settle();
      loc(s, hi, b);
      ev = 0;
      for (int t = 63; t >= 1; t--) begin
        loc(t, hi2, b2);
        if (hi2 == hi && b2 == b) ev = t;
      end
      chk(hi ? "R2" : "R3", $sformatf("irq src %0d", s), {31'b0, irq_o}, {31'b0, ev != 0});
      rd(3'd2, dh); rd(3'd3, dl); rd(3'd4, dv);
      chk(hi ? "R2" : "R3", $sformatf("pend hi src %0d", s), dh, hi ? (32'h1 << b) : 32'h0);
      chk(hi ? "R2" : "R3", $sformatf("pend lo src %0d", s), dl, hi ? 32'h0 : (32'h1 << b));
      chk("R9", $sformatf("vector src %0d", s), dv, 32'(ev) << 26);
      src_i[s] = 1'b0;
      wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
      settle();
    end
    clean();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    // source 7 -> high bit 9, source 60 -> low bit 28
    @(negedge clk); src_i[7] = 1'b1; src_i[60] = 1'b1;
    settle();
    chk("R4", "all masked irq", {31'b0, irq_o}, 32'h0);
    rd(3'd2, d); chk("R4", "masked still pending", d, 32'h200);
    wr(3'd1, 32'h1000_0000);
    rd(3'd4, d); chk("R4", "only lo enabled vector", d, 32'd60 << 26);
    chk("R10", "irq with vector", {31'b0, irq_o}, 32'h1);
    wr(3'd0, 32'h0000_0200);
    rd(3'd4, d); chk("R9", "lowest wins", d, 32'd7 << 26);
    src_i[7] = 1'b0; src_i[60] = 1'b0;
    settle();
    clean();
    chk("R10", "irq after clean", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    // 33 -> high 30, 40 -> high 23, 3 -> high 13
    @(negedge clk); src_i[33] = 1'b1; src_i[40] = 1'b1; src_i[3] = 1'b1;
    settle();
    wr(3'd2, 32'h0080_0000);
    rd(3'd2, d); chk("R5", "clear one bit", d, 32'h4000_2000);
    wr(3'd2, 32'h0);
    rd(3'd2, d); chk("R5", "zero write keeps", d, 32'h4000_2000);
    src_i[33] = 1'b0; src_i[40] = 1'b0; src_i[3] = 1'b0;
    settle();
    clean();
  endtask

  task automatic t_sense();
    logic [31:0] d;
    wr(3'd1, 32'hFFFF_FFFF);
    // source 20 -> low bit 13, falling edge
    @(negedge clk); sense_i[41:40] = 2'd2; src_i[20] = 1'b1;
    settle();
    rd(3'd3, d); chk("R6", "falling ignores rise", d, 32'h0);
    @(negedge clk); src_i[20] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6", "not yet at second edge", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R6", "set at third edge", {31'b0, irq_o}, 32'h1);
    rd(3'd3, d); chk("R6", "falling pending", d, 32'h2000);
    wr(3'd3, 32'hFFFF_FFFF);
    // source 50 -> low bit 18, active-low level
    @(negedge clk); src_i[50] = 1'b1;
    settle();
    wr(3'd3, 32'hFFFF_FFFF);
    @(negedge clk); sense_i[101:100] = 2'd0;
    settle();
    rd(3'd3, d); chk("R6", "low level idle high", d, 32'h0);
    @(negedge clk); src_i[50] = 1'b0;
    settle();
    rd(3'd3, d); chk("R6", "low level active", d, 32'h0004_0000);
    @(negedge clk); src_i[50] = 1'b1;
    settle();
    sense_i = '1;
    clean();
  endtask

  task automatic t_level();
    logic [31:0] d;
    // source 40 -> high bit 23, active-high level
    @(negedge clk); sense_i[81:80] = 2'd1; src_i[40] = 1'b1;
    settle();
    wr(3'd2, 32'h0080_0000);
    rd(3'd2, d); chk("R7", "level stays pending", d, 32'h0080_0000);
    @(negedge clk); src_i[40] = 1'b0;
    settle();
    wr(3'd2, 32'h0080_0000);
    rd(3'd2, d); chk("R7", "inactive level clears", d, 32'h0);
    sense_i = '1;
    clean();
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    // source 5 -> high bit 11
    @(negedge clk); src_i[5] = 1'b1;
    settle();
    @(negedge clk); src_i[5] = 1'b0;
    settle();
    @(negedge clk); src_i[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 3'd2; wdata = 32'h800;
    @(negedge clk); wr_en = 1'b0;
    rd(3'd2, d); chk("R8", "set beats clear", d, 32'h800);
    src_i[5] = 1'b0;
    settle();
    clean();
  endtask

  task automatic t_edge_once();
    logic [31:0] d;
    // source 63 -> low bit 31
    @(negedge clk); src_i[63] = 1'b1;
    settle();
    wr(3'd3, 32'h8000_0000);
    repeat (6) @(negedge clk);
    rd(3'd3, d); chk("R12", "held edge stays clear", d, 32'h0);
    src_i[63] = 1'b0;
    settle();
    clean();
  endtask

  task automatic t_src0();
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_FFFF);
    @(negedge clk); src_i[0] = 1'b1;
    settle();
    chk("R9", "source 0 no irq", {31'b0, irq_o}, 32'h0);
    rd(3'd2, d); chk("R9", "source 0 pending", d, 32'h1);
    rd(3'd4, d); chk("R9", "source 0 vector zero", d, 32'h0);
    src_i[0] = 1'b0;
    settle();
    clean();
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(3'd1, 32'h0000_0004);
    @(negedge clk); src_i[16] = 1'b1;
    settle();
    wr(3'd5, 32'hA5A5_0001); wr(3'd6, 32'h1234_5678); wr(3'd7, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd5, d); chk("R11", "config readback", d, 32'hA5A5_0001);
    rd(3'd6, d); chk("R11", "prio hi readback", d, 32'h1234_5678);
    rd(3'd7, d); chk("R11", "prio lo readback", d, 32'h0);
    rd(3'd4, d); chk("R11", "vector unaffected", d, 32'd16 << 26);
    chk("R11", "irq unaffected", {31'b0, irq_o}, 32'h1);
    src_i[16] = 1'b0;
    settle();
    clean();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_mask();
    t_w1c();
    t_sense();
    t_level();
    t_setwins();
    t_edge_once();
    t_src0();
    t_cfg();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule